// File: doc/BRIEF.md
# Serial Control Latch Receiver

This block receives a 20-bit control word over three wires: a data line, a shift clock and a load strobe. Each rising edge of the shift clock moves the current data bit into a shift register, least significant bit first. A separate high-then-low pulse on the load strobe copies the shifted word into a parallel output latch. Until that strobe falls, the control outputs keep their previous values, so the host can shift a full word without any glitch on the outputs.

All three wires are asynchronous to the system clock. They pass through a two-stage synchroniser and their edges are detected in the system clock domain. Each high or low phase on a wire must therefore last at least two system clocks. The latched word drives these outputs: codec trim chip-select, clock, data and mute; converter calibrate, reset and mute lines; memory interface selects and strobes; an LED; and two source-select fields for the digital audio outputs.

Top module: `ctl_serial_latch`

## Requirements
- R1: While reset is high, the shift register and the output latch clear to zero, so every output reads 0 until the first load.
- R2: Bits are taken least significant first. After exactly 20 shift pulses, the first bit shifted sits at word bit 0 and the last bit at word bit 19.
- R3: The outputs do not change while bits are being shifted, nor at any other time other than a load strobe falling edge.
- R4: Raising the load strobe alone does not update the outputs. The latch copies all 20 shift register bits on the strobe's high-to-low transition.
- R5: The low fifteen word bits map to the control outputs as follows. Bit 0 is the encoded-audio select (active low). Bits 1 to 5 are the memory data select, memory control select (active low), memory clock, memory chip select and memory serial out. Bits 6 to 9 are the trim chip select (active low), trim clock, trim data and trim mute (active low). Bit 10 is the ADC calibrate line, passed through at its level, where high stops calibration. Bit 11 is the ADC reset (active low), bit 12 the DAC calibrate, bit 13 the DAC mute (active low) and bit 14 the LED (active low).
- R6: Word bits 16:15 form the 2-bit source select for the first digital audio output. Word bits 19:17 form the 3-bit source select for the second.
- R7: When more than 20 shift pulses come before a load, the oldest bits are discarded and the latch receives the most recent 20 bits.
- R8: The data line is sampled at the rising edge of the shift clock. A change of the data line while the shift clock is high has no effect on the captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Serial data line |
| shift_clk_pulse | input | 1 | Shift clock line, sampled on rise |
| load_pulse | input | 1 | Load strobe, copies on fall |
| ac3_sel_n | output | 1 | Encoded-audio data select, active low (bit 0) |
| rom_data_sel | output | 1 | Memory data select (bit 1) |
| rom_ctl_sel_n | output | 1 | Memory control select, active low (bit 2) |
| rom_clk | output | 1 | Memory clock (bit 3) |
| rom_cs | output | 1 | Memory chip select (bit 4) |
| rom_sdo | output | 1 | Memory serial out (bit 5) |
| trim_cs_n | output | 1 | Trim chip select, active low (bit 6) |
| trim_sclk | output | 1 | Trim serial clock (bit 7) |
| trim_sdata | output | 1 | Trim serial data (bit 8) |
| trim_mute_n | output | 1 | Trim mute, active low (bit 9) |
| adc_cal | output | 1 | ADC calibrate, high stops calibration (bit 10) |
| adc_rst_n | output | 1 | ADC reset, active low (bit 11) |
| dac_cal | output | 1 | DAC calibrate (bit 12) |
| dac_mute_n | output | 1 | DAC mute, active low (bit 13) |
| led_n | output | 1 | LED, active low (bit 14) |
| dao0_sel | output | 2 | First digital audio output source select (bits 16:15) |
| dao1_sel | output | 3 | Second digital audio output source select (bits 19:17) |

## Verification
The checker tests the following on every cycle. The latch stays put unless a synchronised load fall occurs, and then it takes the shift register's prior contents. The shift register moves only on a detected shift clock rise, and each shift places the synchronised data bit at the top. The latch is zero after reset. The bench scenarios show end-to-end properties that only the ports reveal: least significant bit first ordering, the field positions of each output, and that a raised but unreleased strobe changes nothing. They also show that surplus shifts keep only the newest 20 bits and that data changes during a high shift clock are ignored.

// File: rtl/ctl_latch_pkg.sv
package ctl_latch_pkg;

    localparam int CTL_W       = 20;
    localparam int SYNC_STAGES = 2;
    localparam int SYNC_W      = 3;
    localparam int IDX_DATA    = 0;
    localparam int IDX_SCLK    = 1;
    localparam int IDX_LOAD    = 2;

    // Field order below is most significant first; bit 0 is ac3_sel_n.
    typedef struct packed {
        logic [2:0] dao1_sel;
        logic [1:0] dao0_sel;
        logic       led_n;
        logic       dac_mute_n;
        logic       dac_cal;
        logic       adc_rst_n;
        logic       adc_cal;
        logic       trim_mute_n;
        logic       trim_sdata;
        logic       trim_sclk;
        logic       trim_cs_n;
        logic       rom_sdo;
        logic       rom_cs;
        logic       rom_clk;
        logic       rom_ctl_sel_n;
        logic       rom_data_sel;
        logic       ac3_sel_n;
    } ctl_word_t;

    function automatic ctl_word_t to_ctl_word(input logic [CTL_W-1:0] raw);
        return ctl_word_t'(raw);
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/ctl_edge_det.sv
module ctl_edge_det #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = prev & ~lvl;
        end else begin : g_rise
            assign pulse = lvl & ~prev;
        end
    endgenerate
endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    // New bit enters at the top; after W shifts the first bit is at bit 0.
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (shift_en) q <= {din, q[W-1:1]};
    end
endmodule

// File: rtl/ctl_latch_reg.sv
module ctl_latch_reg
    import ctl_latch_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  ctl_word_t d,
    output ctl_word_t q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (capture) q <= d;
    end
endmodule

// File: rtl/ctl_serial_latch.sv
module ctl_serial_latch
    import ctl_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       data_in,
    input  logic       shift_clk_pulse,
    input  logic       load_pulse,
    output logic       ac3_sel_n,
    output logic       rom_data_sel,
    output logic       rom_ctl_sel_n,
    output logic       rom_clk,
    output logic       rom_cs,
    output logic       rom_sdo,
    output logic       trim_cs_n,
    output logic       trim_sclk,
    output logic       trim_sdata,
    output logic       trim_mute_n,
    output logic       adc_cal,
    output logic       adc_rst_n,
    output logic       dac_cal,
    output logic       dac_mute_n,
    output logic       led_n,
    output logic [1:0] dao0_sel,
    output logic [2:0] dao1_sel
);
    logic [SYNC_W-1:0] wires_raw;
    logic [SYNC_W-1:0] wires_s;
    logic              data_s;
    logic              sclk_rise;
    logic              load_fall;
    logic [CTL_W-1:0]  shreg_q;
    ctl_word_t         latch_q;

    assign wires_raw[IDX_DATA] = data_in;
    assign wires_raw[IDX_SCLK] = shift_clk_pulse;
    assign wires_raw[IDX_LOAD] = load_pulse;

    ctl_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (wires_raw),
        .dout(wires_s)
    );

    assign data_s = wires_s[IDX_DATA];

    ctl_edge_det #(.FALLING(1'b0)) u_sclk_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (wires_s[IDX_SCLK]),
        .pulse(sclk_rise)
    );

    ctl_edge_det #(.FALLING(1'b1)) u_load_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (wires_s[IDX_LOAD]),
        .pulse(load_fall)
    );

    ctl_shifter #(.W(CTL_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .shift_en(sclk_rise),
        .din     (data_s),
        .q       (shreg_q)
    );

    ctl_latch_reg u_latch (
        .clk    (clk),
        .rst    (rst),
        .capture(load_fall),
        .d      (to_ctl_word(shreg_q)),
        .q      (latch_q)
    );

    assign ac3_sel_n     = latch_q.ac3_sel_n;
    assign rom_data_sel  = latch_q.rom_data_sel;
    assign rom_ctl_sel_n = latch_q.rom_ctl_sel_n;
    assign rom_clk       = latch_q.rom_clk;
    assign rom_cs        = latch_q.rom_cs;
    assign rom_sdo       = latch_q.rom_sdo;
    assign trim_cs_n     = latch_q.trim_cs_n;
    assign trim_sclk     = latch_q.trim_sclk;
    assign trim_sdata    = latch_q.trim_sdata;
    assign trim_mute_n   = latch_q.trim_mute_n;
    assign adc_cal       = latch_q.adc_cal;
    assign adc_rst_n     = latch_q.adc_rst_n;
    assign dac_cal       = latch_q.dac_cal;
    assign dac_mute_n    = latch_q.dac_mute_n;
    assign led_n         = latch_q.led_n;
    assign dao0_sel      = latch_q.dao0_sel;
    assign dao1_sel      = latch_q.dao1_sel;
endmodule

// File: rtl/ctl_serial_latch_chk.sv
module ctl_serial_latch_chk
    import ctl_latch_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input ctl_word_t        word_q,
    input logic [CTL_W-1:0] shreg_q,
    input logic             sclk_rise,
    input logic             load_fall,
    input logic             data_s
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (word_q == '0));

    p_hold_between_loads_r3: assert property (@(posedge clk) disable iff (rst)
        !load_fall |=> $stable(word_q));

    p_capture_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        load_fall |=> (word_q == $past(shreg_q)));

    p_insert_at_top_r2: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> (shreg_q[CTL_W-1] == $past(data_s)));

    p_shift_only_on_rise_r8: assert property (@(posedge clk) disable iff (rst)
        !sclk_rise |=> $stable(shreg_q));
endmodule

bind ctl_serial_latch ctl_serial_latch_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .word_q   (latch_q),
    .shreg_q  (shreg_q),
    .sclk_rise(sclk_rise),
    .load_fall(load_fall),
    .data_s   (data_s)
);

// File: tb/ctl_serial_latch_tb.sv
`timescale 1ns/1ps
module ctl_serial_latch_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_in = 1'b0;
    logic shift_clk_pulse = 1'b0;
    logic load_pulse = 1'b0;
    logic ac3_sel_n, rom_data_sel, rom_ctl_sel_n, rom_clk, rom_cs, rom_sdo;
    logic trim_cs_n, trim_sclk, trim_sdata, trim_mute_n;
    logic adc_cal, adc_rst_n, dac_cal, dac_mute_n, led_n;
    logic [1:0] dao0_sel;
    logic [2:0] dao1_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [19:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    logic [19:0] last_exp = '0;

    always #4 clk = ~clk;

    ctl_serial_latch u_dut (
        .clk(clk), .rst(rst), .data_in(data_in),
        .shift_clk_pulse(shift_clk_pulse), .load_pulse(load_pulse),
        .ac3_sel_n(ac3_sel_n), .rom_data_sel(rom_data_sel),
        .rom_ctl_sel_n(rom_ctl_sel_n), .rom_clk(rom_clk), .rom_cs(rom_cs),
        .rom_sdo(rom_sdo), .trim_cs_n(trim_cs_n), .trim_sclk(trim_sclk),
        .trim_sdata(trim_sdata), .trim_mute_n(trim_mute_n), .adc_cal(adc_cal),
        .adc_rst_n(adc_rst_n), .dac_cal(dac_cal), .dac_mute_n(dac_mute_n),
        .led_n(led_n), .dao0_sel(dao0_sel), .dao1_sel(dao1_sel)
    );

    // Word assembled from the ports following the R5/R6 bit layout.
    function automatic logic [19:0] observed();
        return {dao1_sel, dao0_sel, led_n, dac_mute_n, dac_cal, adc_rst_n,
                adc_cal, trim_mute_n, trim_sdata, trim_sclk, trim_cs_n,
                rom_sdo, rom_cs, rom_clk, rom_ctl_sel_n, rom_data_sel, ac3_sel_n};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic shift_bit(input logic b, input bit flip_high);
        data_in = b;
        wait_cyc(3);
        shift_clk_pulse = 1'b1;
        wait_cyc(3);
        if (flip_high) data_in = ~b;
        wait_cyc(3);
        shift_clk_pulse = 1'b0;
        wait_cyc(3);
    endtask

    task automatic pulse_load(input bit check_high);
        load_pulse = 1'b1;
        wait_cyc(6);
        if (check_high) begin
            @(negedge clk);
            check("R4 strobe high only", {12'h0, observed()}, {12'h0, last_exp});
            wait_cyc(1);
        end
        load_pulse = 1'b0;
        wait_cyc(6);
    endtask

    // Driver: shifts n bits of v, v[0] first, then strobes and queues the expectation.
    task automatic send(input logic [31:0] v, input int n, input string tag,
                        input bit mid_check, input bit hold_check, input bit flip);
        logic [19:0] e;
        for (int i = 0; i < n; i++) begin
            shift_bit(v[i], flip);
            if (mid_check && i == 10) begin
                @(negedge clk);
                check("R3 stable mid shift", {12'h0, observed()}, {12'h0, last_exp});
                wait_cyc(1);
            end
        end
        e = 20'(v >> (n - 20));
        pulse_load(hold_check);
        sb_q.push_back('{exp: e, tag: tag});
        last_exp = e;
        wait_cyc(3);
    endtask

    // Monitor: compares queued expectations against the ports.
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(it.tag, {12'h0, observed()}, {12'h0, it.exp});
            end
        end
    end

    initial begin
        wait_cyc(150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        @(negedge clk);
        check("R1 reset outputs zero", {12'h0, observed()}, 32'h0);
        wait_cyc(1);
        rst = 1'b0;
        wait_cyc(3);
        @(negedge clk);
        check("R1 zero after reset release", {12'h0, observed()}, 32'h0);
        wait_cyc(1);

        send(32'h00001, 20, "R2 first bit lands at bit0", 0, 0, 0);
        send(32'h80000, 20, "R2 last bit lands at bit19", 1, 0, 0);
        send(32'h5A5A5, 20, "R5 alternating pattern", 1, 1, 0);
        send(32'hFFFFF, 20, "R4 all ones copied", 0, 1, 0);
        send(32'h00000, 20, "R4 all zeros copied", 1, 0, 0);
        send(32'h0B0400, 20, "R6 select fields", 0, 0, 0);
        wait_cyc(2);
        @(negedge clk);
        check("R6 first select bits 16:15", {30'h0, dao0_sel}, 32'd2);
        check("R6 second select bits 19:17", {29'h0, dao1_sel}, 32'd5);
        check("R5 adc_cal bit10 passthrough", {31'h0, adc_cal}, 32'd1);
        check("R5 led_n bit14 low", {31'h0, led_n}, 32'd0);
        wait_cyc(1);
        send(32'h04A21, 20, "R5 sparse fields", 0, 0, 0);
        wait_cyc(2);
        @(negedge clk);
        check("R5 ac3_sel_n bit0", {31'h0, ac3_sel_n}, 32'd1);
        check("R5 rom_sdo bit5", {31'h0, rom_sdo}, 32'd1);
        check("R5 trim_mute_n bit9", {31'h0, trim_mute_n}, 32'd1);
        check("R5 led_n bit14", {31'h0, led_n}, 32'd1);
        wait_cyc(1);
        send(32'h1ABCDEF, 25, "R7 latest twenty bits kept", 0, 0, 0);
        send(32'h3C96A, 20, "R8 data change while clock high ignored", 0, 0, 1);

        // R1 reset mid-word clears the latch again
        shift_bit(1'b1, 0);
        rst = 1'b1;
        wait_cyc(2);
        @(negedge clk);
        check("R1 reset after load clears", {12'h0, observed()}, 32'h0);
        wait_cyc(1);
        rst = 1'b0;
        wait_cyc(4);

        wait (sb_q.size() == 0);
        wait_cyc(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule